// File: doc/BRIEF.md
# Series Lithium Pack Protection Controller

This block is the decision core of a protector for a stack of five to ten lithium cells in series. Comparator results and time-qualified fault events reach it as synchronous single-bit inputs. From them it decides whether the charge switch and the discharge switch may conduct, whether the protector is awake, and whether a small test current should be driven to detect that an offending load has been removed. Analog comparison, gate driving, regulation and delay timing are handled elsewhere.

The controller has three states. SLEEP is entered from reset, on a qualified undervoltage event and on a sleep request. In SLEEP both switches are off and no trip is monitored. The wake transition SLEEP to MEASURE happens when the wake condition holds. MEASURE lasts exactly one cycle: the block is awake and captures trips, but both switches stay off. It always moves on to ACTIVE. ACTIVE drives the switches from a set of per-fault release latches. Each fault has its own release rule. The transition ACTIVE to SLEEP is taken on an undervoltage event when no overcurrent is latched, or on a sleep request. Entering SLEEP from ACTIVE clears the overvoltage, overcurrent and short-circuit latches. The undervoltage latch survives sleep.

Charger detection depends on the configuration pin. With the pin low, the pack-above-stack comparator flag is the detector. With the pin high, a high level on the sleep input is the detector.

Top module: `pack_guard_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the block in SLEEP. `chg_en`, `dsg_en`, `awake` and `tst_en` are all 0 during reset and on the first cycle after it.
- R2: The block leaves SLEEP when the wake condition holds, spends one cycle in MEASURE (`awake`=1, both enables 0), then enters ACTIVE with both enables 1 if no fault is present. If no undervoltage is latched, the wake condition is `pack_near` and (`sleep_pin` or `chg_above`) when `bal_cfg`=0, and `sleep_pin` and `pack_near` when `bal_cfg`=1.
- R3: In ACTIVE, `sleep_pin`=0 moves the block to SLEEP only if no charger is detected. Charger detect is `chg_above` when `bal_cfg`=0 and `sleep_pin` when `bal_cfg`=1.
- R4: An `ov_evt` seen while awake clears `chg_en` and leaves `dsg_en` unchanged. `chg_en` returns once every active cell's `ce_below` bit is 1.
- R5: An `uv_evt` in ACTIVE with no overcurrent latched clears both enables and `awake`, and latches undervoltage.
- R6: With undervoltage latched and `bal_cfg`=0, wake needs `chg_above` while any active cell has `rel_above`=0, and needs only `pack_near` once all active cells have it set. With `bal_cfg`=1, wake needs `sleep_pin` and `pack_near`.
- R7: While undervoltage is latched in ACTIVE, `chg_en` is 1 only if a charger is detected and `dsg_en` stays 0. The latch clears when every active cell has `rel_above`=1.
- R8: A `doc_trip` or `sc_trip` clears `dsg_en`, sets `tst_en` and leaves `chg_en` unchanged. It is released on a cycle with `pack_near`=1 and no new trip. A trip wins over a release in the same cycle.
- R9: An `uv_evt` while an overcurrent is latched keeps the block in ACTIVE with `tst_en`=1 and `dsg_en`=0. `chg_en` follows R7.
- R10: An `uv_evt` while only a short circuit is latched sends the block to SLEEP with `tst_en`=0. The short-circuit latch is discarded.
- R11: While `dly_fault`=1 both enables are 0. They return on the cycle after it clears.
- R12: Only cells with index below the effective count are evaluated. The effective count is `cell_cnt` clamped to 5..10. Bit i of `ce_below` and `rel_above` belongs to cell i.
- R13: Every output changes only at the clock edge that samples its cause, never between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_cnt | input | 4 | Number of cells in the stack |
| ce_below | input | 10 | Per cell: below the charge-enable level |
| rel_above | input | 10 | Per cell: above the undervoltage release level |
| ov_evt | input | 1 | Qualified overvoltage event on some cell |
| uv_evt | input | 1 | Qualified undervoltage event on some cell |
| doc_trip | input | 1 | Qualified discharge overcurrent trip |
| sc_trip | input | 1 | Qualified short-circuit trip |
| chg_above | input | 1 | Pack terminal above stack by the charger margin |
| pack_near | input | 1 | Pack terminal within the test margin of the stack |
| sleep_pin | input | 1 | Sleep input, low requests sleep |
| bal_cfg | input | 1 | Charger-detect mode select |
| dly_fault | input | 1 | Delay pin near a supply rail |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| awake | output | 1 | 1 when in MEASURE or ACTIVE |
| tst_en | output | 1 | Load-removal test current enable |

## Verification
The assertions check these properties on every cycle: the switches are off in SLEEP and MEASURE, a delay fault or any trip removes the matching enable one edge later, an undervoltage event without a latched overcurrent leads to sleep, the test current never runs together with discharge, and a set latch always captures its event. Only the bench scenarios can show the release paths and their dependence on charger-detect mode: the undervoltage wake rules, the charge-enable recovery over a masked cell count, and the test-current outcome when undervoltage arrives during an overcurrent or a short circuit.

// File: rtl/pkprot_pkg.sv
`timescale 1ns/1ps
package pkprot_pkg;

    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_MEASURE = 2'd1,
        ST_ACTIVE  = 2'd2
    } pstate_e;

    // release latch slots
    localparam int LAT_OV  = 0;
    localparam int LAT_DOC = 1;
    localparam int LAT_SC  = 2;
    localparam int NLAT    = 3;

endpackage

// File: rtl/pack_guard_cells.sv
`timescale 1ns/1ps
module pack_guard_cells #(
    parameter int NCELL     = 10,
    parameter int MIN_CELLS = 5,
    parameter int CNT_W     = $clog2(NCELL + 1)
) (
    input  logic [CNT_W-1:0] cell_cnt,
    input  logic [NCELL-1:0] ce_below,
    input  logic [NCELL-1:0] rel_above,
    output logic             all_ce,
    output logic             all_rel
);
    localparam logic [CNT_W-1:0] CNT_LO = CNT_W'(MIN_CELLS);
    localparam logic [CNT_W-1:0] CNT_HI = CNT_W'(NCELL);

    logic [CNT_W-1:0] eff_cnt;
    logic [NCELL-1:0] used;

    // R12 clamp the cell count into the legal range
    always_comb begin
        if (cell_cnt < CNT_LO)
            eff_cnt = CNT_LO;
        else if (cell_cnt > CNT_HI)
            eff_cnt = CNT_HI;
        else
            eff_cnt = cell_cnt;
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_mask
        assign used[g] = (32'(eff_cnt) > 32'(g));
    end

    // unused cell positions count as satisfied
    assign all_ce  = &(ce_below  | ~used);
    assign all_rel = &(rel_above | ~used);

endmodule

// File: rtl/pack_guard_detect.sv
`timescale 1ns/1ps
module pack_guard_detect (
    input  logic bal_cfg,
    input  logic sleep_pin,
    input  logic chg_above,
    input  logic pack_near,
    input  logic uv_latched,
    input  logic all_rel,
    output logic chg_det,
    output logic sleep_req,
    output logic wake_ok
);
    logic wake_uv;
    logic wake_plain;

    // R3 charger detect source chosen by the configuration pin
    assign chg_det   = bal_cfg ? sleep_pin : chg_above;
    assign sleep_req = !sleep_pin && !chg_det;

    // R6 release path after undervoltage
    always_comb begin
        if (bal_cfg)
            wake_uv = sleep_pin && pack_near;
        else if (all_rel)
            wake_uv = pack_near;
        else
            wake_uv = chg_above;
    end

    // R2 ordinary wake
    always_comb begin
        if (bal_cfg)
            wake_plain = sleep_pin && pack_near;
        else
            wake_plain = pack_near && (sleep_pin || chg_above);
    end

    assign wake_ok = uv_latched ? wake_uv : wake_plain;

endmodule

// File: rtl/pack_guard_latch.sv
`timescale 1ns/1ps
module pack_guard_latch (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic q,
    output logic q_nxt
);
    always_comb begin
        q_nxt = q;
        if (flush)
            q_nxt = 1'b0;
        else if (en && set)
            q_nxt = 1'b1;
        else if (en && clr)
            q_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= q_nxt;
    end

    // R8
    latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (en && set && !flush) |=> q);

endmodule

// File: rtl/pack_guard_fsm.sv
`timescale 1ns/1ps
module pack_guard_fsm
    import pkprot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake_ok,
    input  logic sleep_req,
    input  logic chg_det,
    input  logic uv_evt,
    input  logic doc_hold,
    input  logic all_rel,
    input  logic dly_fault,
    input  logic ov_nxt,
    input  logic doc_nxt,
    input  logic sc_nxt,
    output logic flush,
    output logic awake,
    output logic uv_lat,
    output logic chg_en,
    output logic dsg_en,
    output logic tst_en
);
    pstate_e st_q;
    pstate_e st_d;
    logic    uv_d;
    logic    go_active;

    always_comb begin
        st_d = st_q;
        uv_d = uv_lat;
        unique case (st_q)
            ST_SLEEP: begin
                if (wake_ok)
                    st_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (all_rel)
                    uv_d = 1'b0;
                if (uv_evt) begin
                    uv_d = 1'b1;
                    if (!doc_hold)
                        st_d = ST_SLEEP;
                end else if (sleep_req) begin
                    st_d = ST_SLEEP;
                end
            end
            default: st_d = ST_SLEEP;
        endcase
    end

    assign flush     = (st_q == ST_ACTIVE) && (st_d == ST_SLEEP);
    assign go_active = (st_d == ST_ACTIVE);
    assign awake     = (st_q != ST_SLEEP);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_SLEEP;
            uv_lat <= 1'b0;
        end else begin
            st_q   <= st_d;
            uv_lat <= uv_d;
        end
    end

    // registered outputs, derived from next-state values (R13)
    always_ff @(posedge clk) begin
        if (rst) begin
            chg_en <= 1'b0;
            dsg_en <= 1'b0;
            tst_en <= 1'b0;
        end else begin
            chg_en <= go_active && !ov_nxt && !(uv_d && !chg_det) && !dly_fault;
            dsg_en <= go_active && !uv_d && !doc_nxt && !sc_nxt && !dly_fault;
            tst_en <= go_active && (doc_nxt || sc_nxt);
        end
    end

    // R5
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SLEEP) |-> (!chg_en && !dsg_en && !tst_en));

    // R2
    measure_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MEASURE) |-> (!chg_en && !dsg_en));

    // R11
    dly_off_chk: assert property (@(posedge clk) disable iff (rst)
        dly_fault |=> (!chg_en && !dsg_en));

    // R5
    uv_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_ACTIVE) && uv_evt && !doc_hold) |=> (st_q == ST_SLEEP));

endmodule

// File: rtl/pack_guard_ctrl.sv
`timescale 1ns/1ps
module pack_guard_ctrl #(
    parameter int NCELL     = 10,
    parameter int MIN_CELLS = 5,
    parameter int CNT_W     = $clog2(NCELL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cell_cnt,
    input  logic [NCELL-1:0] ce_below,
    input  logic [NCELL-1:0] rel_above,
    input  logic             ov_evt,
    input  logic             uv_evt,
    input  logic             doc_trip,
    input  logic             sc_trip,
    input  logic             chg_above,
    input  logic             pack_near,
    input  logic             sleep_pin,
    input  logic             bal_cfg,
    input  logic             dly_fault,
    output logic             chg_en,
    output logic             dsg_en,
    output logic             awake,
    output logic             tst_en
);
    import pkprot_pkg::*;

    logic            all_ce, all_rel;
    logic            chg_det, sleep_req, wake_ok;
    logic            uv_lat, flush;
    logic [NLAT-1:0] lat_q, lat_nxt, lat_set, lat_clr;

    pack_guard_cells #(
        .NCELL(NCELL), .MIN_CELLS(MIN_CELLS), .CNT_W(CNT_W)
    ) u_cells (
        .cell_cnt (cell_cnt),
        .ce_below (ce_below),
        .rel_above(rel_above),
        .all_ce   (all_ce),
        .all_rel  (all_rel)
    );

    pack_guard_detect u_detect (
        .bal_cfg   (bal_cfg),
        .sleep_pin (sleep_pin),
        .chg_above (chg_above),
        .pack_near (pack_near),
        .uv_latched(uv_lat),
        .all_rel   (all_rel),
        .chg_det   (chg_det),
        .sleep_req (sleep_req),
        .wake_ok   (wake_ok)
    );

    // release rules per latch: OV on charge-enable, trips on pack near stack
    assign lat_set[LAT_OV]  = ov_evt;
    assign lat_clr[LAT_OV]  = all_ce;
    assign lat_set[LAT_DOC] = doc_trip;
    assign lat_clr[LAT_DOC] = pack_near;
    assign lat_set[LAT_SC]  = sc_trip;
    assign lat_clr[LAT_SC]  = pack_near;

    for (genvar k = 0; k < NLAT; k++) begin : g_lat
        pack_guard_latch u_lat (
            .clk  (clk),
            .rst  (rst),
            .en   (awake),
            .flush(flush),
            .set  (lat_set[k]),
            .clr  (lat_clr[k]),
            .q    (lat_q[k]),
            .q_nxt(lat_nxt[k])
        );
    end

    pack_guard_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wake_ok  (wake_ok),
        .sleep_req(sleep_req),
        .chg_det  (chg_det),
        .uv_evt   (uv_evt),
        .doc_hold (lat_q[LAT_DOC] || doc_trip),
        .all_rel  (all_rel),
        .dly_fault(dly_fault),
        .ov_nxt   (lat_nxt[LAT_OV]),
        .doc_nxt  (lat_nxt[LAT_DOC]),
        .sc_nxt   (lat_nxt[LAT_SC]),
        .flush    (flush),
        .awake    (awake),
        .uv_lat   (uv_lat),
        .chg_en   (chg_en),
        .dsg_en   (dsg_en),
        .tst_en   (tst_en)
    );

    // R4
    ov_cut_chk: assert property (@(posedge clk) disable iff (rst)
        ov_evt |=> !chg_en);

    // R8
    trip_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (doc_trip || sc_trip) |=> !dsg_en);

    // R10
    tst_scope_chk: assert property (@(posedge clk) disable iff (rst)
        tst_en |-> (awake && !dsg_en));

endmodule

// File: tb/pack_guard_ctrl_tb.sv
`timescale 1ns/1ps
module pack_guard_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [40:0] cur;
    logic [3:0]  cell_cnt;
    logic [9:0]  ce_below, rel_above;
    logic        ov_evt, uv_evt, doc_trip, sc_trip;
    logic        chg_above, pack_near, sleep_pin, bal_cfg, dly_fault;
    logic        chg_en, dsg_en, awake, tst_en;
    logic [3:0]  outs;
    int          checks = 0;
    int          fails  = 0;

    always #5 clk = ~clk;

    // row: cnt(4) ce(10) rel(10) ov uv doc sc chga near slp cfg flt | exp chg dsg awk tst | req
    assign {cell_cnt, ce_below, rel_above, ov_evt, uv_evt, doc_trip, sc_trip,
            chg_above, pack_near, sleep_pin, bal_cfg, dly_fault} = cur[40:8];
    assign outs = {chg_en, dsg_en, awake, tst_en};

    pack_guard_ctrl u_dut (
        .clk(clk), .rst(rst), .cell_cnt(cell_cnt), .ce_below(ce_below),
        .rel_above(rel_above), .ov_evt(ov_evt), .uv_evt(uv_evt),
        .doc_trip(doc_trip), .sc_trip(sc_trip), .chg_above(chg_above),
        .pack_near(pack_near), .sleep_pin(sleep_pin), .bal_cfg(bal_cfg),
        .dly_fault(dly_fault), .chg_en(chg_en), .dsg_en(dsg_en),
        .awake(awake), .tst_en(tst_en)
    );

    localparam logic [40:0] TBL [0:41] = '{
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0010, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b100001100, 4'b0110, 4'd4},
        {4'd10, 10'h3FE, 10'h3FF, 9'b000001100, 4'b0110, 4'd4},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd4},
        {4'd10, 10'h3FF, 10'h3FF, 9'b001000100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000000100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001101, 4'b0010, 4'd11},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd11},
        {4'd5,  10'h01F, 10'h3FF, 9'b100001100, 4'b0110, 4'd12},
        {4'd5,  10'h01F, 10'h3FF, 9'b000001100, 4'b1110, 4'd12},
        {4'd3,  10'h017, 10'h3FF, 9'b100001100, 4'b0110, 4'd12},
        {4'd3,  10'h017, 10'h3FF, 9'b000001100, 4'b0110, 4'd12},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd12},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001000, 4'b0000, 4'd3},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001000, 4'b0000, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000011000, 4'b0010, 4'd3},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000011000, 4'b1110, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000011000, 4'b1110, 4'd3},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000011010, 4'b0000, 4'd3},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001010, 4'b0000, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001110, 4'b0010, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001110, 4'b1110, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010001100, 4'b0000, 4'd5},
        {4'd10, 10'h3FF, 10'h3FE, 9'b000001100, 4'b0000, 4'd6},
        {4'd10, 10'h3FF, 10'h3FE, 9'b000011100, 4'b0010, 4'd6},
        {4'd10, 10'h3FF, 10'h3FE, 9'b000011100, 4'b1010, 4'd7},
        {4'd10, 10'h3FF, 10'h3FE, 9'b000001100, 4'b0010, 4'd7},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000011100, 4'b1110, 4'd7},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010001100, 4'b0000, 4'd5},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001000, 4'b0010, 4'd6},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0010, 4'd7},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd7},
        {4'd10, 10'h3FF, 10'h3FF, 9'b001000100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010000100, 4'b0011, 4'd9},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd9},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000100100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010000100, 4'b0000, 4'd10},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0010, 4'd10},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0010, 4'd10},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd10}
    };

    localparam logic [40:0] TRIPS [0:4] = '{
        {4'd10, 10'h3FF, 10'h3FF, 9'b000101100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b001100100, 4'b1011, 4'd8},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010000100, 4'b0011, 4'd9},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd9}
    };

    localparam logic [40:0] CFGHI [0:6] = '{
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0010, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd2},
        {4'd10, 10'h3FF, 10'h3FF, 9'b010001100, 4'b0000, 4'd5},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000010110, 4'b0000, 4'd6},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001110, 4'b0010, 4'd6},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001110, 4'b1010, 4'd7},
        {4'd10, 10'h3FF, 10'h3FF, 9'b000001110, 4'b1110, 4'd7}
    };

    localparam logic [40:0] BASE = {4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b0000, 4'd1};
    localparam logic [40:0] OVR  = {4'd10, 10'h3FF, 10'h3FF, 9'b100001100, 4'b0000, 4'd4};

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            4'd12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input logic [3:0] req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: outputs chg/dsg/awk/tst got %b expected %b", rname(req), got, exp);
        end
    endtask

    task automatic step(input logic [40:0] r);
        cur = r;
        @(negedge clk);
        check(r[3:0], outs, r[7:4]);
    endtask

    initial begin
        cur = BASE;
        repeat (3) @(negedge clk);
        check(4'd1, outs, 4'b0000);          // R1 during reset
        rst = 1'b0;
        for (int i = 0; i < 42; i++)
            step(TBL[i]);

        // R13: nothing moves before the sampling edge
        cur = OVR;
        #1;
        check(4'd13, outs, 4'b1110);
        @(negedge clk);
        check(4'd4, outs, 4'b0110);
        step({4'd10, 10'h3FF, 10'h3FF, 9'b000001100, 4'b1110, 4'd4});

        // R8 / R9 trip corner cases
        for (int i = 0; i < 5; i++)
            step(TRIPS[i]);

        // R1 reset from ACTIVE
        rst = 1'b1;
        cur = BASE;
        @(negedge clk);
        check(4'd1, outs, 4'b0000);
        rst = 1'b0;

        // R6 / R7 undervoltage release with the configuration pin high
        for (int i = 0; i < 7; i++)
            step(CFGHI[i]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R13: watchdog got no completion expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule